// File: doc/BRIEF.md
# Rotating-Priority DMA Channel Arbiter

This block decides which of six DMA channels may run next. Each channel raises a request line. The arbiter grants one channel, and that grant stays in place for the whole transfer. The transfer engine then reports completion with a one-cycle end pulse. Outputs are a one-hot grant vector, a busy flag and the binary index of the granted channel.

Priority rotates. A 3-bit head pointer names the channel that currently ranks highest. The rest of the ranking follows cyclically upward from the head. When a transfer on channel N completes, the head moves to N+1, wrapping from 5 to 0. Channel N therefore drops to the bottom of the ranking. Every channel that ranked between the old head and N also moves down, whether or not it was requesting.

A grant is issued on the clock edge that ends an idle cycle in which at least one request is present. After an end pulse the arbiter spends one idle cycle, then picks a new winner from the requests seen in that cycle.

Top module: `rr_dma_arbiter`

## Requirements
- R1: After reset, grant is 0, busy is 0, grant_idx is 0 and channel 0 ranks highest (order 0,1,2,3,4,5).
- R2: When several channels request in the same idle cycle, the one ranked highest in the current order is granted; requests on channels 0 and 3 after reset grant channel 0.
- R3: At most one grant bit is set. busy is 1 exactly when a grant bit is set, and grant_idx is the number of that bit, or 0 while idle. A grant appears on the edge that ends an idle cycle with any request set.
- R4: While busy and no end pulse is present, grant and grant_idx stay unchanged, even when requests change or a higher-ranked channel starts requesting.
- R5: An end pulse (xfer_done=1) while busy clears grant and busy on the next edge. The following idle cycle selects the next winner from the requests present then.
- R6: When a transfer on channel N ends, channel (N+1) mod 6 becomes highest and N becomes lowest. After channel 0 ends with channels 1 and 3 pending, channel 1 wins. After channel 5 ends, channel 0 is highest.
- R7: Rotation is cyclic over all channels. With channel 2 highest, ending a transfer on channel 3 makes channel 4 highest, so channel 4 then beats channel 2.
- R8: An end pulse while idle is ignored: no grant is produced and the ranking is unchanged.
- R9: With no request present while idle, no grant is issued and busy stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 6 | Per-channel transfer request, bit i for channel i |
| xfer_done | input | 1 | One-cycle pulse marking the end of the active transfer |
| grant | output | 6 | One-hot grant, bit i for channel i |
| busy | output | 1 | A transfer is granted and not yet ended |
| grant_idx | output | 3 | Binary number of the granted channel, 0 when idle |

## Verification
The assertions check the following on every cycle:
- the grant is one-hot;
- busy agrees with the grant vector and with grant_idx;
- a held grant does not move until the end pulse, and is released on the edge after it;
- an idle cycle grants exactly when some request is present.

Rotation cannot be seen from one cycle alone. This covers which channel wins under a given ranking, the wrap from 5 to 0, skipped channels being demoted, and an idle end pulse leaving the head alone. The bench's scenarios show these by ordering successive grants and comparing each grant against a scoreboard of expected winners.

// File: rtl/rra_pkg.sv
package rra_pkg;
  localparam int unsigned CHANNELS = 6;
  localparam int unsigned CH_IDX_W = $clog2(CHANNELS);
endpackage

// File: rtl/rra_pick.sv
// Combinational winner search: scan cyclically upward from the head
// pointer and return the first requesting channel.
module rra_pick #(
  parameter int unsigned NCH  = 6,
  parameter int unsigned IDXW = 3
) (
  input  logic [NCH-1:0]  req,
  input  logic [IDXW-1:0] head,
  output logic            any,
  output logic [IDXW-1:0] win
);
  localparam logic [IDXW:0] NCH_W = (IDXW+1)'(NCH);

  logic [IDXW:0] cand;

  always_comb begin
    any  = 1'b0;
    win  = '0;
    cand = '0;
    for (int off = 0; off < NCH; off++) begin
      cand = {1'b0, head} + (IDXW+1)'(off);
      if (cand >= NCH_W) cand = cand - NCH_W;
      if (!any && req[cand[IDXW-1:0]]) begin
        any = 1'b1;
        win = cand[IDXW-1:0];
      end
    end
  end
endmodule

// File: rtl/rra_hold.sv
// Grant holder: latches a winner while idle, keeps it until the end pulse.
module rra_hold #(
  parameter int unsigned NCH  = 6,
  parameter int unsigned IDXW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            any,
  input  logic [IDXW-1:0] win,
  input  logic            done,
  output logic [NCH-1:0]  grant,
  output logic            busy,
  output logic [IDXW-1:0] idx,
  output logic            fire
);
  logic [NCH-1:0]  grant_d;
  logic            busy_d;
  logic [IDXW-1:0] idx_d;
  logic            load_en;

  assign fire = busy & done;

  always_comb begin
    grant_d = grant;
    busy_d  = busy;
    idx_d   = idx;
    load_en = 1'b0;
    if (busy) begin
      if (done) begin
        load_en = 1'b1;
        grant_d = '0;
        busy_d  = 1'b0;
        idx_d   = '0;
      end
    end else if (any) begin
      load_en = 1'b1;
      grant_d = NCH'(1) << win;
      busy_d  = 1'b1;
      idx_d   = win;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant <= '0;
      busy  <= 1'b0;
      idx   <= '0;
    end else if (load_en) begin
      grant <= grant_d;
      busy  <= busy_d;
      idx   <= idx_d;
    end
  end
endmodule

// File: rtl/rra_rot.sv
// Head pointer: moves to the channel after the one that just finished.
module rra_rot #(
  parameter int unsigned NCH  = 6,
  parameter int unsigned IDXW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  logic [IDXW-1:0] idx,
  output logic [IDXW-1:0] head
);
  localparam logic [IDXW-1:0] LAST = IDXW'(NCH - 1);

  logic [IDXW-1:0] head_d;

  always_comb begin
    head_d = (idx == LAST) ? '0 : idx + IDXW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) head <= '0;
    else if (fire) head <= head_d;
  end
endmodule

// File: rtl/rr_dma_arbiter.sv
module rr_dma_arbiter #(
  parameter int unsigned NCH  = rra_pkg::CHANNELS,
  parameter int unsigned IDXW = rra_pkg::CH_IDX_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  req,
  input  logic            xfer_done,
  output logic [NCH-1:0]  grant,
  output logic            busy,
  output logic [IDXW-1:0] grant_idx
);
  logic [IDXW-1:0] head;
  logic [IDXW-1:0] win;
  logic            any;
  logic            fire;

  rra_pick #(.NCH(NCH), .IDXW(IDXW)) u_pick (
    .req(req), .head(head), .any(any), .win(win)
  );

  rra_hold #(.NCH(NCH), .IDXW(IDXW)) u_hold (
    .clk(clk), .rst_n(rst_n), .any(any), .win(win), .done(xfer_done),
    .grant(grant), .busy(busy), .idx(grant_idx), .fire(fire)
  );

  rra_rot #(.NCH(NCH), .IDXW(IDXW)) u_rot (
    .clk(clk), .rst_n(rst_n), .fire(fire), .idx(grant_idx), .head(head)
  );
endmodule

// File: rtl/rra_arb_chk.sv
module rra_arb_chk #(
  parameter int unsigned NCH  = 6,
  parameter int unsigned IDXW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NCH-1:0]  req,
  input logic            xfer_done,
  input logic [NCH-1:0]  grant,
  input logic            busy,
  input logic [IDXW-1:0] grant_idx
);
  p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_busy_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy == (grant != '0));

  p_idx_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> grant[grant_idx]);

  p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req != '0) |=> busy);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !xfer_done) |=> (busy && $stable(grant) && $stable(grant_idx)));

  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && xfer_done) |=> !busy);

  p_no_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req == '0) |=> !busy);
endmodule

bind rr_dma_arbiter rra_arb_chk #(.NCH(NCH), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .xfer_done(xfer_done),
  .grant(grant), .busy(busy), .grant_idx(grant_idx)
);

// File: tb/rr_dma_arbiter_test.sv
`timescale 1ns/1ps
module rr_dma_arbiter_test;
  logic       clk;
  logic       rst_n;
  logic [5:0] req;
  logic       xfer_done;
  logic [5:0] grant;
  logic       busy;
  logic [2:0] grant_idx;

  int n_chk;
  int n_bad;
  int exp_q[$];
  logic busy_seen;

  rr_dma_arbiter uut (
    .clk(clk), .rst_n(rst_n), .req(req), .xfer_done(xfer_done),
    .grant(grant), .busy(busy), .grant_idx(grant_idx)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // Monitor: each newly started grant is popped from the scoreboard.
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && !busy_seen) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected grant", int'(grant_idx), -1);
        end else begin
          int e;
          e = exp_q.pop_front();
          check(int'(grant_idx) == e, "R2/R6/R7 winner", int'(grant_idx), e);
          check(grant == (6'd1 << e), "R3 one-hot grant", int'(grant), int'(6'd1 << e));
        end
      end
      busy_seen <= busy;
    end else begin
      busy_seen <= 1'b0;
    end
  end

  // Driver: raise requests and queue the expected winner.
  task automatic start(input logic [5:0] r, input int exp);
    exp_q.push_back(exp);
    req = r;
    @(negedge clk);
    check(busy == 1'b1, "R3 busy after request", int'(busy), 1);
  endtask

  // Driver: end the active transfer, dropping that channel's request.
  task automatic finish(input int ch, input int nxt);
    if (nxt >= 0) exp_q.push_back(nxt);
    xfer_done = 1'b1;
    req[ch] = 1'b0;
    @(negedge clk);
    xfer_done = 1'b0;
    check(busy == 1'b0 && grant == 6'd0, "R5 release after end", int'(busy), 0);
    check(grant_idx == 3'd0, "R3 idle index", int'(grant_idx), 0);
    if (nxt >= 0) begin
      @(negedge clk);
      check(busy == 1'b1, "R5 next winner picked", int'(busy), 1);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    req = '0; xfer_done = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(grant == 6'd0 && busy == 1'b0, "R1 reset outputs", int'(grant), 0);
    check(grant_idx == 3'd0, "R1 reset index", int'(grant_idx), 0);

    // R9: no requests, no grant
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && grant == 6'd0, "R9 idle without request", int'(busy), 0);

    // R2: channels 0 and 3 together -> 0
    start(6'b001001, 0);
    // R4: late request on 1 does not preempt; grant stays stable
    req[1] = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(grant == 6'b000001 && grant_idx == 3'd0, "R4 grant held", int'(grant), 1);
    end
    req = 6'b001011;
    @(negedge clk);
    check(grant == 6'b000001, "R4 held under changing requests", int'(grant), 1);

    // R6: after 0 ends, 1 beats 3
    finish(0, 1);
    // Channel 1 ends; head now 2, only 3 pending
    finish(1, 3);
    // R7: channel 3 ends with head at 2 -> head 4
    finish(3, -1);

    // R8: end pulse while idle is ignored
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
    check(busy == 1'b0, "R8 idle pulse gives no grant", int'(busy), 0);
    @(negedge clk);

    // R7/R8: channels 1, 2 and 4 request; head must still be 4
    start(6'b010110, 4);
    finish(4, -1);
    req = '0;
    @(negedge clk);

    // R6: head 5, channels 0 and 5 -> 5
    start(6'b100001, 5);
    // R6 wrap: after 5 ends, head 0 -> channel 0
    finish(5, 0);
    finish(0, -1);
    @(negedge clk);

    // R2: head 1, channels 0 and 2 -> 2
    start(6'b000101, 2);
    finish(2, 0);
    finish(0, -1);
    @(negedge clk);
    check(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule